// File: doc/BRIEF.md
# Pedestrian Crossing Controller with Countdown

This block sequences the lamps at a push-button pedestrian crossing and shows how many seconds are left in the current timed phase. A four-state machine is at its core. The go state (`ST_GO`) holds vehicle green and pedestrian red until a request arrives. The request moves the machine into the amber phase (`ST_AMBER`), then into the walk phase (`ST_WALK`), and then into a guard phase (`ST_GUARD`) before it returns to `ST_GO`. The guard phase shows the same lamps as `ST_GO`, but it refuses requests for its whole length. This gives the vehicle lane a minimum green time after every crossing.

Timing works on two levels. A prescaler emits a one-cycle tick every `TICKS_PER_SEC` clocks. A small seconds counter advances on each tick. A phase ends when the seconds count equals the phase length minus one and a tick arrives. Both counters clear on every state change, so each phase starts from zero. The seconds remaining (phase length minus elapsed seconds) drive two active-low seven-segment digits. The tens digit is blanked when it is zero, and both digits are blank in `ST_GO`.

The named transitions are:
- `ST_GO`→`ST_AMBER` on a request.
- `ST_AMBER`→`ST_WALK` when the amber phase ends.
- `ST_WALK`→`ST_GUARD` when the walk phase ends.
- `ST_GUARD`→`ST_GO` when the guard phase ends.

Top module: `ped_xing_ctrl`

## Requirements
- R1: The active-low `rst_n` acts asynchronously. While it is low the block is in `ST_GO` with both counters at zero: lamps show vehicle green and pedestrian red, and both digits are blank.
- R2: In `ST_GO` the lamps are vehicle green and pedestrian red. The block stays in `ST_GO` for as long as `ped_req` is low.
- R3: When `ped_req` is high in `ST_GO` at a clock edge, the block is in `ST_AMBER` after that edge. A request held high is acted on at the first edge the block spends in `ST_GO`.
- R4: `ST_AMBER` shows vehicle yellow and pedestrian red. It lasts exactly `AMBER_SECS*TICKS_PER_SEC` cycles (default 5 s) and then enters `ST_WALK`.
- R5: `ST_WALK` shows vehicle red and pedestrian green. It lasts exactly `WALK_SECS*TICKS_PER_SEC` cycles (default 10 s) and then enters `ST_GUARD`.
- R6: `ST_GUARD` shows the same lamps as `ST_GO`. It lasts exactly `GUARD_SECS*TICKS_PER_SEC` cycles (default 10 s) regardless of `ped_req`, and then enters `ST_GO`.
- R7: A request seen in `ST_AMBER`, `ST_WALK` or `ST_GUARD` is discarded and not queued. This includes a request seen in the last guard cycle: with `ped_req` low afterwards, the block stays in `ST_GO`.
- R8: The prescaler emits a one-cycle tick every `TICKS_PER_SEC` clocks, and the seconds counter advances by one on each tick. Both clear on every state change and are held at zero in `ST_GO`.
- R9: In a timed phase the displayed value is the phase length minus the elapsed whole seconds. For the defaults this counts 5..1 in amber and 10..1 in walk and guard.
- R10: Each digit bus is active-low, with bit 6 down to bit 0 driving segments g,f,e,d,c,b,a. The digits 0–9 are 0x40, 0x79, 0x24, 0x30, 0x19, 0x12, 0x02, 0x78, 0x00, 0x10, and blank is 0x7F. The tens digit is blank when the value is below 10, and both digits are blank in `ST_GO`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ped_req | input | 1 | Pedestrian crossing request, level sampled at each edge |
| veh_grn | output | 1 | Vehicle green lamp |
| veh_yel | output | 1 | Vehicle yellow lamp |
| veh_red | output | 1 | Vehicle red lamp |
| ped_grn | output | 1 | Pedestrian green lamp |
| ped_red | output | 1 | Pedestrian red lamp |
| seg_tens_n | output | 7 | Tens digit, active-low, bits g..a |
| seg_ones_n | output | 7 | Ones digit, active-low, bits g..a |

## Verification
Two events can fall in the same cycle: the end of a phase and an incoming request. The sharpest case is the guard phase expiring on the same edge that `ped_req` is high, which must not start a new crossing. The bench provokes this twice. A pulsed run places a request exactly in the last guard cycle. A held run keeps `ped_req` high across whole cycles and expects exactly one `ST_GO` cycle between crossings. Every cycle of each phase is compared against lamp and digit values computed arithmetically from the cycle count since entry into amber.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
    typedef enum logic [1:0] {
        ST_GO    = 2'd0,
        ST_AMBER = 2'd1,
        ST_WALK  = 2'd2,
        ST_GUARD = 2'd3
    } xing_state_t;

    localparam int SEG_W      = 7;
    localparam int NUM_DIGITS = 2;
    localparam logic [SEG_W-1:0] SEG_BLANK = 7'h7F;
endpackage

// File: rtl/pxc_prescale.sv
module pxc_prescale #(
    parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (clr || tick)  cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);                                          // R8
    AST_PRESCALE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));                                  // R8
endmodule

// File: rtl/pxc_seconds.sv
module pxc_seconds #(
    parameter int unsigned SEC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [SEC_W-1:0] secs
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     secs <= '0;
        else if (clr)   secs <= '0;
        else if (tick)  secs <= secs + 1'b1;
    end

    AST_SEC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> (secs == $past(secs) + 1'b1));        // R8
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(secs));                       // R8
endmodule

// File: rtl/pxc_seg7.sv
module pxc_seg7
    import pxc_pkg::*;
(
    input  logic [3:0]       value,
    input  logic             blank,
    output logic [SEG_W-1:0] seg_n
);
    always_comb begin
        if (blank) begin
            seg_n = SEG_BLANK;
        end else begin
            case (value)
                4'd0:    seg_n = 7'h40;
                4'd1:    seg_n = 7'h79;
                4'd2:    seg_n = 7'h24;
                4'd3:    seg_n = 7'h30;
                4'd4:    seg_n = 7'h19;
                4'd5:    seg_n = 7'h12;
                4'd6:    seg_n = 7'h02;
                4'd7:    seg_n = 7'h78;
                4'd8:    seg_n = 7'h00;
                4'd9:    seg_n = 7'h10;
                default: seg_n = SEG_BLANK;
            endcase
        end
    end
endmodule

// File: rtl/ped_xing_ctrl.sv
module ped_xing_ctrl
    import pxc_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 50_000_000,
    parameter int unsigned SEC_W         = 4,
    parameter int unsigned AMBER_SECS    = 5,
    parameter int unsigned WALK_SECS     = 10,
    parameter int unsigned GUARD_SECS    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ped_req,
    output logic             veh_grn,
    output logic             veh_yel,
    output logic             veh_red,
    output logic             ped_grn,
    output logic             ped_red,
    output logic [SEG_W-1:0] seg_tens_n,
    output logic [SEG_W-1:0] seg_ones_n
);
    localparam logic [SEC_W-1:0] AMBER_LEN = SEC_W'(AMBER_SECS);
    localparam logic [SEC_W-1:0] WALK_LEN  = SEC_W'(WALK_SECS);
    localparam logic [SEC_W-1:0] GUARD_LEN = SEC_W'(GUARD_SECS);
    localparam logic [SEC_W-1:0] TEN       = SEC_W'(10);

    xing_state_t      state_q, state_d;
    logic             tick, clr, phase_end;
    logic [SEC_W-1:0] secs, phase_len, remain, ones_bin;
    logic             tens_bin;
    logic [3:0]       dig_val   [NUM_DIGITS];
    logic             dig_blank [NUM_DIGITS];
    logic [SEG_W-1:0] dig_seg   [NUM_DIGITS];

    // timing chain
    pxc_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_prescale (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick)
    );
    pxc_seconds #(.SEC_W(SEC_W)) u_seconds (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .secs(secs)
    );

    always_comb begin
        unique case (state_q)
            ST_AMBER: phase_len = AMBER_LEN;
            ST_WALK:  phase_len = WALK_LEN;
            ST_GUARD: phase_len = GUARD_LEN;
            ST_GO:    phase_len = '0;
        endcase
    end

    assign phase_end = tick && (secs == phase_len - 1'b1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GO:    if (ped_req)   state_d = ST_AMBER;
            ST_AMBER: if (phase_end) state_d = ST_WALK;
            ST_WALK:  if (phase_end) state_d = ST_GUARD;
            ST_GUARD: if (phase_end) state_d = ST_GO;
        endcase
    end

    assign clr = (state_q == ST_GO) || (state_d != state_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_GO;
        else        state_q <= state_d;
    end

    // lamp outputs
    always_comb begin
        veh_grn = 1'b0;
        veh_yel = 1'b0;
        veh_red = 1'b0;
        ped_grn = 1'b0;
        ped_red = 1'b0;
        unique case (state_q)
            ST_GO, ST_GUARD: begin veh_grn = 1'b1; ped_red = 1'b1; end
            ST_AMBER:        begin veh_yel = 1'b1; ped_red = 1'b1; end
            ST_WALK:         begin veh_red = 1'b1; ped_grn = 1'b1; end
        endcase
    end

    // countdown display
    assign remain   = phase_len - secs;
    assign tens_bin = (remain >= TEN);
    assign ones_bin = tens_bin ? (remain - TEN) : remain;

    assign dig_val[0]   = 4'(ones_bin);
    assign dig_blank[0] = (state_q == ST_GO);
    assign dig_val[1]   = {3'b000, tens_bin};
    assign dig_blank[1] = (state_q == ST_GO) || !tens_bin;

    for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_digit
        pxc_seg7 u_seg (
            .value(dig_val[gi]), .blank(dig_blank[gi]), .seg_n(dig_seg[gi])
        );
    end

    assign seg_ones_n = dig_seg[0];
    assign seg_tens_n = dig_seg[1];

    // assertions
    AST_GO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GO && !ped_req) |=> (state_q == ST_GO));          // R2
    AST_GO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GO && ped_req) |=> (state_q == ST_AMBER));        // R3
    AST_GUARD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GUARD && !tick) |=> (state_q == ST_GUARD));       // R6
    AST_NO_REQ_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_GUARD && state_q == ST_GO && !ped_req)
        |=> (state_q == ST_GO));                                         // R7
    AST_PHASE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d != state_q) |=> (secs == '0));                          // R8
    AST_LAMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({veh_grn, veh_yel, veh_red}) == 1) && (ped_grn != ped_red)); // R2
    AST_WALK_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        ped_grn |-> veh_red);                                            // R5
endmodule

// File: tb/tb_ped_xing_ctrl.sv
`timescale 1ns/1ps
module tb_ped_xing_ctrl;
    localparam int T   = 4;
    localparam int AS  = 5;
    localparam int WS  = 10;
    localparam int GS  = 10;
    localparam int A_END = AS * T;
    localparam int W_END = A_END + WS * T;
    localparam int G_END = W_END + GS * T;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ped_req = 1'b0;
    logic veh_grn, veh_yel, veh_red, ped_grn, ped_red;
    logic [6:0] seg_tens_n, seg_ones_n;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    ped_xing_ctrl #(
        .TICKS_PER_SEC(T), .SEC_W(4),
        .AMBER_SECS(AS), .WALK_SECS(WS), .GUARD_SECS(GS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ped_req(ped_req),
        .veh_grn(veh_grn), .veh_yel(veh_yel), .veh_red(veh_red),
        .ped_grn(ped_grn), .ped_red(ped_red),
        .seg_tens_n(seg_tens_n), .seg_ones_n(seg_ones_n)
    );

    always #2 clk = ~clk;

    function automatic logic [6:0] seg_of(input int d);
        case (d)
            0: return 7'h40;  1: return 7'h79;  2: return 7'h24;
            3: return 7'h30;  4: return 7'h19;  5: return 7'h12;
            6: return 7'h02;  7: return 7'h78;  8: return 7'h00;
            9: return 7'h10;  default: return 7'h7F;
        endcase
    endfunction

    // phase code: 0 go, 1 amber, 2 walk, 3 guard
    function automatic int phase_of(input int m);
        if (m < A_END) return 1;
        if (m < W_END) return 2;
        if (m < G_END) return 3;
        return 0;
    endfunction

    function automatic logic [4:0] lamps_of(input int ph);
        case (ph)
            1: return 5'b01001;
            2: return 5'b00110;
            default: return 5'b10001;
        endcase
    endfunction

    function automatic logic [13:0] disp_of(input int m);
        int ph, rem;
        ph = phase_of(m);
        if (ph == 0) return {7'h7F, 7'h7F};
        if (ph == 1)      rem = AS - m / T;
        else if (ph == 2) rem = WS - (m - A_END) / T;
        else              rem = GS - (m - W_END) / T;
        return {(rem >= 10) ? seg_of(rem / 10) : 7'h7F, seg_of(rem % 10)};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string lamp_tag(input int ph);
        case (ph)
            1: return "R4 amber lamps";
            2: return "R5 walk lamps";
            3: return "R6 guard lamps";
            default: return "R2 go lamps";
        endcase
    endfunction

    task automatic check_cycle(input int m);
        int ph;
        ph = phase_of(m);
        check(lamp_tag(ph), int'({veh_grn, veh_yel, veh_red, ped_grn, ped_red}), int'(lamps_of(ph)));
        check((ph == 0) ? "R10 go blank" : "R9 R10 countdown digits",
              int'({seg_tens_n, seg_ones_n}), int'(disp_of(m)));
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #3;
        check("R1 reset lamps", int'({veh_grn, veh_yel, veh_red, ped_grn, ped_red}), 5'b10001);
        check("R1 reset digits", int'({seg_tens_n, seg_ones_n}), int'({7'h7F, 7'h7F}));
        @(negedge clk);
        rst_n = 1'b1;

        // R2: idle in go without request
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check_cycle(G_END);
        end

        // Pulsed run: requests during timed phases and in the last guard cycle (R7)
        ped_req = 1'b1;
        @(negedge clk);
        for (int n = 0; n < G_END + 20; n++) begin
            check_cycle(n);   // R3 R4 R5 R6 R8 R9 timing per cycle
            ped_req = (n < G_END) && ((n % 7 == 3) || (n == G_END - 1));
            @(negedge clk);
        end
        ped_req = 1'b0;

        // R1: asynchronous reset in the middle of walk
        ped_req = 1'b1;
        @(negedge clk);
        ped_req = 1'b0;
        repeat (A_END + 3 * T) @(negedge clk);
        check_cycle(A_END + 3 * T);
        #1 rst_n = 1'b0;
        #0.5;
        check("R1 async reset lamps", int'({veh_grn, veh_yel, veh_red, ped_grn, ped_red}), 5'b10001);
        check("R1 async reset digits", int'({seg_tens_n, seg_ones_n}), int'({7'h7F, 7'h7F}));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_cycle(G_END);

        // R3 R6: held request, one go cycle between crossings
        ped_req = 1'b1;
        @(negedge clk);
        for (int n = 0; n < 2 * (G_END + 1) + 5; n++) begin
            check_cycle(n % (G_END + 1));
            if (n % (G_END + 1) == G_END)
                check("R3 held request single go cycle", int'(veh_grn), 1);
            @(negedge clk);
        end
        ped_req = 1'b0;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule